// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Controller

This block sits between the byte FIFOs of an SPI controller and the rest of the chip. It holds a transmit FIFO, which the bus side fills and the serial engine drains, and a receive FIFO, which the serial engine fills and the bus side drains. It tracks how full each FIFO is and compares each fill count with its own programmable threshold. From those comparisons it drives two DMA request lines and two level-type interrupt sources. It also records a receive overflow event and a transfer-complete event.

The four sources are latched in a status word that software clears by writing ones to it. A separate enable word decides which latched sources reach the single interrupt output. One control word holds both thresholds, both DMA enables and two self-clearing flush bits. A packed status word reports both fill counts.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: Each FIFO is first-in first-out. A push is accepted only while the count is below DEPTH, and a pop only while the count is above zero. The head output always shows the oldest stored byte.
- R2: `fifo_sts` packs the fill counts. The RX count is in bits 7:0 and the TX count in bits 23:16. All other bits read zero. The counts change on the clock edge after the push or pop.
- R3: A `cfg_wr` word holds these fields: RX threshold in bits 7:0, RX DMA enable in bit 8, RX flush in bit 15, TX threshold in bits 23:16, TX DMA enable in bit 24 and TX flush in bit 31. A flush bit empties its FIFO at the next edge and is not stored. A push or pop to that FIFO in the same cycle has no effect.
- R4: Status bit 0 (RX ready) is set on each edge at which the registered RX count is at or above the RX threshold.
- R5: Status bit 4 (TX request) is set on each edge at which the registered TX count is at or below the TX threshold.
- R6: Status bit 8 (RX overflow) is set when `rx_push` arrives while the RX FIFO holds DEPTH bytes and no RX flush is requested. That byte is discarded.
- R7: Status bit 12 (transfer complete) is set one edge after a `xfer_done` pulse.
- R8: Writing a one to a status bit clears it. Writing zero leaves it unchanged. If a source's set condition is true in the same cycle as the clear, the bit stays set, so a level source whose condition still holds is set again.
- R9: `irq_o` is high exactly when some status bit is one and its enable bit is also one. The enable word uses the status layout, and writes to any other bit are ignored.
- R10: `rx_dma_req` is high while the RX DMA enable is set and the RX count is at or above the RX threshold. `tx_dma_req` is high while the TX DMA enable is set and the TX count is at or below the TX threshold. Both follow the registered counts with no further delay.
- R11: Reset clears both FIFOs, both thresholds, both DMA enables, the enable word and the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word: thresholds, DMA enables, flush bits |
| ien_wr | input | 1 | Write strobe for the interrupt enable word |
| ien_wdata | input | 32 | New interrupt enable word |
| sts_clr_wr | input | 1 | Write strobe for clearing status bits |
| sts_clr_wdata | input | 32 | Ones mark the status bits to clear |
| tx_push | input | 1 | Bus side writes a byte into the TX FIFO |
| tx_push_data | input | 8 | Byte written into the TX FIFO |
| tx_pop | input | 1 | Serial engine takes the TX head byte |
| tx_head | output | 8 | Oldest byte in the TX FIFO |
| rx_push | input | 1 | Serial engine delivers a received byte |
| rx_push_data | input | 8 | Received byte |
| rx_pop | input | 1 | Bus side takes the RX head byte |
| rx_head | output | 8 | Oldest byte in the RX FIFO |
| xfer_done | input | 1 | One-cycle pulse at the end of a transfer |
| fifo_sts | output | 32 | Packed fill counts |
| irq_sts | output | 32 | Latched interrupt status word |
| irq_o | output | 1 | Interrupt request |
| rx_dma_req | output | 1 | RX DMA request |
| tx_dma_req | output | 1 | TX DMA request |

## Verification
The bench fills the receive FIFO past DEPTH. A design that kept the extra byte, wrapped its count or missed the overflow flag would show a wrong count, a wrong head byte or a missing bit 8. It clears a level source whose condition is still true and expects the bit back. A design in which the clear wins would lose that bit. It also flushes while pushing in the same cycle, and it compares each threshold at its exact boundary, where an off-by-one comparison would set RX ready, TX request or a DMA line one byte early or late.

// File: rtl/spi_fic_pkg.sv
package spi_fic_pkg;
    localparam int BYTE_W   = 8;
    localparam int CNT_FW   = 8;
    localparam int NSRC     = 4;

    // status / enable bit positions, index = source number
    localparam int SRC_POS [NSRC] = '{0, 4, 8, 12};

    // control word fields
    localparam int C_RXTRIG = 0;
    localparam int C_RXDMA  = 8;
    localparam int C_RXFL   = 15;
    localparam int C_TXTRIG = 16;
    localparam int C_TXDMA  = 24;
    localparam int C_TXFL   = 31;

    typedef struct packed {
        logic [CNT_FW-1:0] rx_trig;
        logic [CNT_FW-1:0] tx_trig;
        logic              rx_dma_en;
        logic              tx_dma_en;
    } fic_cfg_t;
endpackage

// File: rtl/fic_byte_fifo.sv
module fic_byte_fifo
    import spi_fic_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop,
    output logic [BYTE_W-1:0] head,
    output logic [CNT_FW-1:0] count,
    output logic              drop
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic full, empty, push_ok, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (ptr_q.cnt == CW'(DEPTH));
        empty   = (ptr_q.cnt == '0);
        push_ok = push && !full && !flush;
        pop_ok  = pop && !empty && !flush;
        drop    = push && full && !flush;
        ptr_d   = ptr_q;
        if (flush) begin
            ptr_d = '0;
        end else begin
            if (push_ok) ptr_d.wr = bump(ptr_q.wr);
            if (pop_ok)  ptr_d.rd = bump(ptr_q.rd);
            ptr_d.cnt = ptr_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[ptr_q.wr] <= push_data;
    end

    assign head  = mem_q[ptr_q.rd];
    assign count = CNT_FW'(ptr_q.cnt);
endmodule

// File: rtl/fic_irq_regs.sv
module fic_irq_regs
    import spi_fic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_set,
    input  logic            ien_wr,
    input  logic [NSRC-1:0] ien_wdata,
    input  logic            clr_wr,
    input  logic [NSRC-1:0] clr_wdata,
    output logic [NSRC-1:0] sts,
    output logic [NSRC-1:0] ien,
    output logic            irq
);
    typedef struct packed {
        logic [NSRC-1:0] sts;
        logic [NSRC-1:0] ien;
    } irq_regs_t;

    irq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < NSRC; i++) begin
            r_d.sts[i] = src_set[i] || (r_q.sts[i] && !(clr_wr && clr_wdata[i]));
        end
        if (ien_wr) r_d.ien = ien_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sts = r_q.sts;
    assign ien = r_q.ien;
    assign irq = |(r_q.sts & r_q.ien);
endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
    import spi_fic_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    input  logic        ien_wr,
    input  logic [31:0] ien_wdata,
    input  logic        sts_clr_wr,
    input  logic [31:0] sts_clr_wdata,
    input  logic        tx_push,
    input  logic [7:0]  tx_push_data,
    input  logic        tx_pop,
    output logic [7:0]  tx_head,
    input  logic        rx_push,
    input  logic [7:0]  rx_push_data,
    input  logic        rx_pop,
    output logic [7:0]  rx_head,
    input  logic        xfer_done,
    output logic [31:0] fifo_sts,
    output logic [31:0] irq_sts,
    output logic        irq_o,
    output logic        rx_dma_req,
    output logic        tx_dma_req
);
    fic_cfg_t cfg_d, cfg_q;
    logic rx_flush, tx_flush, rx_drop, tx_drop_unused;
    logic [CNT_FW-1:0] rx_cnt, tx_cnt;
    logic rx_ready, tx_req;
    logic [NSRC-1:0] src_set, ien_pick, clr_pick, sts_v, ien_v;

    always_comb begin
        cfg_d    = cfg_q;
        rx_flush = cfg_wr && cfg_wdata[C_RXFL];
        tx_flush = cfg_wr && cfg_wdata[C_TXFL];
        if (cfg_wr) begin
            cfg_d.rx_trig   = cfg_wdata[C_RXTRIG +: CNT_FW];
            cfg_d.tx_trig   = cfg_wdata[C_TXTRIG +: CNT_FW];
            cfg_d.rx_dma_en = cfg_wdata[C_RXDMA];
            cfg_d.tx_dma_en = cfg_wdata[C_TXDMA];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    fic_byte_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_push), .push_data(tx_push_data), .pop(tx_pop),
        .head(tx_head), .count(tx_cnt), .drop(tx_drop_unused)
    );

    fic_byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(rx_push), .push_data(rx_push_data), .pop(rx_pop),
        .head(rx_head), .count(rx_cnt), .drop(rx_drop)
    );

    assign rx_ready   = (rx_cnt >= cfg_q.rx_trig);
    assign tx_req     = (tx_cnt <= cfg_q.tx_trig);
    assign src_set    = {xfer_done, rx_drop, tx_req, rx_ready};
    assign rx_dma_req = cfg_q.rx_dma_en && rx_ready;
    assign tx_dma_req = cfg_q.tx_dma_en && tx_req;

    // gather / scatter the sparse 32-bit layout
    always_comb begin
        irq_sts = '0;
        for (int i = 0; i < NSRC; i++) begin
            ien_pick[i]        = ien_wdata[SRC_POS[i]];
            clr_pick[i]        = sts_clr_wdata[SRC_POS[i]];
            irq_sts[SRC_POS[i]] = sts_v[i];
        end
    end

    fic_irq_regs u_irq (
        .clk(clk), .rst_n(rst_n), .src_set(src_set),
        .ien_wr(ien_wr), .ien_wdata(ien_pick),
        .clr_wr(sts_clr_wr), .clr_wdata(clr_pick),
        .sts(sts_v), .ien(ien_v), .irq(irq_o)
    );

    assign fifo_sts = {8'h00, tx_cnt, 8'h00, rx_cnt};
endmodule

// File: rtl/spi_fifo_irq_ctrl_chk.sv
module spi_fifo_irq_ctrl_chk #(
    parameter int DEPTH = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [31:0] cfg_wdata,
    input logic        sts_clr_wr,
    input logic [31:0] sts_clr_wdata,
    input logic        rx_push,
    input logic        xfer_done,
    input logic [31:0] fifo_sts,
    input logic [31:0] irq_sts,
    input logic        irq_o,
    input logic        rx_dma_req,
    input logic [7:0]  rx_trig,
    input logic        rx_dma_en
);
    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_sts[7:0] <= 8'(DEPTH) && fifo_sts[23:16] <= 8'(DEPTH));

    // R3
    rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[15]) |=> (fifo_sts[7:0] == 8'd0));

    // R6
    overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && fifo_sts[7:0] == 8'(DEPTH) && !(cfg_wr && cfg_wdata[15])) |=> irq_sts[8]);

    // R7
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> irq_sts[12]);

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr_wr && sts_clr_wdata[12] && !xfer_done) |=> !irq_sts[12]);

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_sts != 32'd0));

    // R10
    rx_dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> (rx_dma_en && fifo_sts[7:0] >= rx_trig));
endmodule

bind spi_fifo_irq_ctrl spi_fifo_irq_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .sts_clr_wr(sts_clr_wr), .sts_clr_wdata(sts_clr_wdata),
    .rx_push(rx_push), .xfer_done(xfer_done), .fifo_sts(fifo_sts),
    .irq_sts(irq_sts), .irq_o(irq_o), .rx_dma_req(rx_dma_req),
    .rx_trig(cfg_q.rx_trig), .rx_dma_en(cfg_q.rx_dma_en)
);

// File: tb/spi_fifo_irq_ctrl_tb.sv
module spi_fifo_irq_ctrl_tb;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 64;
    localparam logic [31:0] SMASK = 32'h0000_1111;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_wr = 0, ien_wr = 0, sts_clr_wr = 0;
    logic [31:0] cfg_wdata = 0, ien_wdata = 0, sts_clr_wdata = 0;
    logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, xfer_done = 0;
    logic [7:0] tx_push_data = 0, rx_push_data = 0, tx_head, rx_head;
    logic [31:0] fifo_sts, irq_sts;
    logic irq_o, rx_dma_req, tx_dma_req;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    spi_fifo_irq_ctrl #(.DEPTH(DEPTH)) u_dut (.*);

    // reference model state
    logic [7:0] m_rxq[$], m_txq[$];
    logic [7:0] m_rx_trig = 0, m_tx_trig = 0;
    logic m_rx_dma = 0, m_tx_dma = 0;
    logic [31:0] m_en = 0, m_sts = 0;

    function automatic logic [31:0] exp_fifo_sts(int rxn, int txn);
        return {8'h00, 8'(txn), 8'h00, 8'(rxn)};
    endfunction

    function automatic logic [31:0] next_sts(logic [31:0] cur, int rxn, int txn, logic [7:0] rt,
                                             logic [7:0] tt, logic ovf, logic done,
                                             logic clr_wr, logic [31:0] clr);
        logic [31:0] keep, n;
        keep = clr_wr ? (cur & ~clr) : cur;
        n = keep & SMASK;
        if (rxn >= int'(rt)) n[0]  = 1'b1;
        if (txn <= int'(tt)) n[4]  = 1'b1;
        if (ovf)             n[8]  = 1'b1;
        if (done)            n[12] = 1'b1;
        return n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rxq.delete(); m_txq.delete();
            m_rx_trig = 0; m_tx_trig = 0; m_rx_dma = 0; m_tx_dma = 0;
            m_en = 0; m_sts = 0;
        end else begin
            logic rfl, tfl, ovf;
            int rn, tn;
            rn  = m_rxq.size(); tn = m_txq.size();
            rfl = cfg_wr && cfg_wdata[15];
            tfl = cfg_wr && cfg_wdata[31];
            ovf = rx_push && rn == DEPTH && !rfl;
            m_sts = next_sts(m_sts, rn, tn, m_rx_trig, m_tx_trig, ovf, xfer_done,
                             sts_clr_wr, sts_clr_wdata);
            if (rfl) m_rxq.delete();
            else begin
                if (rx_pop && rn > 0) void'(m_rxq.pop_front());
                if (rx_push && rn < DEPTH) m_rxq.push_back(rx_push_data);
            end
            if (tfl) m_txq.delete();
            else begin
                if (tx_pop && tn > 0) void'(m_txq.pop_front());
                if (tx_push && tn < DEPTH) m_txq.push_back(tx_push_data);
            end
            if (cfg_wr) begin
                m_rx_trig = cfg_wdata[7:0];   m_tx_trig = cfg_wdata[23:16];
                m_rx_dma  = cfg_wdata[8];     m_tx_dma  = cfg_wdata[24];
            end
            if (ien_wr) m_en = ien_wdata & SMASK;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            if (!rst_n) begin
                chk("R11 fifo_sts", fifo_sts, 32'h0);
                chk("R11 irq_sts", irq_sts, 32'h0);
                chk("R11 outs", {29'h0, irq_o, rx_dma_req, tx_dma_req}, 32'h0);
            end else begin
                chk("R2 fifo_sts", fifo_sts, exp_fifo_sts(m_rxq.size(), m_txq.size()));
                chk("R4 rx_ready", {31'h0, irq_sts[0]},  {31'h0, m_sts[0]});
                chk("R5 tx_req",   {31'h0, irq_sts[4]},  {31'h0, m_sts[4]});
                chk("R6 overflow", {31'h0, irq_sts[8]},  {31'h0, m_sts[8]});
                chk("R7 done",     {31'h0, irq_sts[12]}, {31'h0, m_sts[12]});
                chk("R8 sts_word", irq_sts, m_sts);
                chk("R9 irq_o", {31'h0, irq_o}, {31'h0, |(m_sts & m_en)});
                chk("R10 rx_dma", {31'h0, rx_dma_req},
                    {31'h0, m_rx_dma && m_rxq.size() >= int'(m_rx_trig)});
                chk("R10 tx_dma", {31'h0, tx_dma_req},
                    {31'h0, m_tx_dma && m_txq.size() <= int'(m_tx_trig)});
                if (m_rxq.size() > 0) chk("R1 rx_head", {24'h0, rx_head}, {24'h0, m_rxq[0]});
                if (m_txq.size() > 0) chk("R1 tx_head", {24'h0, tx_head}, {24'h0, m_txq[0]});
            end
        end
    end

    task automatic idle();
        cfg_wr = 0; ien_wr = 0; sts_clr_wr = 0; tx_push = 0; tx_pop = 0;
        rx_push = 0; rx_pop = 0; xfer_done = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1;
        step();
        // R3: thresholds and DMA enables, all interrupts enabled
        cfg_wr = 1; cfg_wdata = 32'h0102_010A;   // tx trig 2, tx dma, rx dma, rx trig 10
        ien_wr = 1; ien_wdata = 32'hFFFF_FFFF;
        step();
        for (int i = 0; i < 5; i++) begin tx_push = 1; tx_push_data = 8'(8'hA0 + i); step(); end
        xfer_done = 1;
        step();
        sts_clr_wr = 1; sts_clr_wdata = 32'hFFFF_FFFF;
        step(); step();
        // R8: all-ones clear with every condition false
        chk("R8 all clear", irq_sts, 32'h0);
        chk("R9 irq low", {31'h0, irq_o}, 32'h0);
        // R4 boundary: 9 then 10 bytes
        for (int i = 0; i < 9; i++) begin rx_push = 1; rx_push_data = 8'(i); step(); end
        step();
        chk("R4 below trig", {31'h0, irq_sts[0]}, 32'h0);
        chk("R10 rx dma below", {31'h0, rx_dma_req}, 32'h0);
        rx_push = 1; rx_push_data = 8'h09; step();
        chk("R10 rx dma at trig", {31'h0, rx_dma_req}, 32'h1);
        step();
        chk("R4 at trig", {31'h0, irq_sts[0]}, 32'h1);
        // R8: clearing a level source whose condition holds
        sts_clr_wr = 1; sts_clr_wdata = 32'h1; step(); step();
        chk("R8 level reset", {31'h0, irq_sts[0]}, 32'h1);
        // R6: overfill the RX FIFO
        for (int i = 0; i < DEPTH - 10 + 3; i++) begin rx_push = 1; rx_push_data = 8'(8'h40 + i); step(); end
        step();
        chk("R6 count held", {24'h0, fifo_sts[7:0]}, DEPTH);
        chk("R6 flag", {31'h0, irq_sts[8]}, 32'h1);
        chk("R1 oldest kept", {24'h0, rx_head}, 32'h0);
        // R3: flush both while pushing
        cfg_wr = 1; cfg_wdata = 32'h8102_810A; rx_push = 1; tx_push = 1;
        step();
        chk("R3 flushed", fifo_sts, 32'h0);
        // R5 boundary: tx count 3 vs trig 2
        sts_clr_wr = 1; sts_clr_wdata = 32'hFFFF_FFFF;
        for (int i = 0; i < 3; i++) begin tx_push = 1; tx_push_data = 8'(i); step(); end
        sts_clr_wr = 1; sts_clr_wdata = 32'h10; step(); step();
        chk("R5 above trig", {31'h0, irq_sts[4]}, 32'h0);
        // random phase
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            idle();
            rx_push = ($urandom % 100) < 50; rx_push_data = 8'($urandom);
            rx_pop  = ($urandom % 100) < 40;
            tx_push = ($urandom % 100) < 45; tx_push_data = 8'($urandom);
            tx_pop  = ($urandom % 100) < 45;
            xfer_done = ($urandom % 100) < 3;
            if (($urandom % 100) < 4) begin
                cfg_wr = 1;
                cfg_wdata = $urandom & 32'h7FFF_7FFF;
                cfg_wdata[7:0]   = 8'($urandom % (DEPTH + 2));
                cfg_wdata[23:16] = 8'($urandom % (DEPTH + 2));
                if (($urandom % 100) < 10) cfg_wdata[15] = 1'b1;
                if (($urandom % 100) < 10) cfg_wdata[31] = 1'b1;
            end
            if (($urandom % 100) < 10) begin sts_clr_wr = 1; sts_clr_wdata = $urandom; end
            if (($urandom % 100) < 3)  begin ien_wr = 1; ien_wdata = $urandom; end
        end
        step(); step();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule